// File: doc/BRIEF.md
# I2C Target with Pointer-Addressed Register File

This block is an I2C target that lets a bus host read and write a register file of 8-bit entries held outside the block. The SCL and SDA lines are sampled on a fast system clock through a small synchronizer. Start, repeated start and stop conditions are decoded from edges of the synchronized lines. The block answers only to its own 7-bit device address. When a software-controlled enable is set, it also answers to the general call address for writes.

A host first sends the device address with the write direction, followed by a register address byte. Data bytes that follow in the same write go to consecutive registers. To read, the host sends a repeated start and the device address with the read direction. The target then shifts out the register at the current pointer. Each host acknowledge moves on to the next register, and a host not-acknowledge ends the burst. The pointer wraps at the top of the register file.

Top module: `i2c_regfile_target`

## Requirements
- R1: A START followed by the device address (7 bits, MSB first, then R/W=0) is acknowledged (SDA low in the ninth clock), and so is the following register address byte. Each data byte after it is acknowledged and written through exactly one single-cycle `rf_we` pulse, with `rf_addr` equal to the current pointer and `rf_wdata` equal to the byte.
- R2: Consecutive data bytes in one write go to consecutive registers. The pointer wraps from the last register (127) to 0.
- R3: After a register address has been written, a repeated START followed by the device address with R/W=1 is acknowledged. The target then drives the register at the pointer onto SDA, MSB first, in the next 8 clocks.
- R4: A host ACK (SDA low) after a read byte makes the target send the next register, wrapping from 127 to 0. After a host NACK the target leaves SDA released for every clock until the next START or STOP.
- R5: If the address byte matches neither the device address nor an enabled general call, the target gives no ACK. It ignores all further bytes until the next START.
- R6: The general call address (byte 00h, R/W=0) is acknowledged only while `gc_en` is 1. Address 0 with R/W=1 is never acknowledged.
- R7: In a general call write, every byte is acknowledged, no `rf_we` pulse occurs and the register pointer keeps its earlier value.
- R8: Only the low 7 bits of the register address byte set the pointer. The top bit is ignored.
- R9: `sda_oe` is 0 after reset and after every STOP. It is 1 only in ACK slots and read data bits, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| gc_en | input | 1 | Enables answering the general call address |
| rf_addr | output | 7 | Register file address (current pointer) |
| rf_we | output | 1 | Single-cycle write strobe |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Combinational read data for `rf_addr` |

## Verification
Single-byte writes and reads separate the basic pointer load from the increment path. Multi-byte bursts that start at 7Eh show whether the pointer wraps in both directions. A register byte with its top bit set shows whether that bit is dropped. Foreign addresses and general calls, with the enable both off and on, tell a correct ignore from a spurious acknowledge or write. A read issued with no register byte after a general call exposes whether the general call disturbed the pointer. Clocking on after a host NACK shows whether SDA is truly released.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_REG,
      ST_REG_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_WAIT
   } tgt_state_t;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } bus_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         last  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign dout = chain[STAGES-1];
   assign rise = dout & ~last;
   assign fall = ~dout & last;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
   import i2c_tgt_pkg::*;
(
   input  logic     scl_lvl,
   input  logic     scl_up,
   input  logic     scl_dn,
   input  logic     sda_up,
   input  logic     sda_dn,
   output bus_evt_t evt
);
   always_comb begin
      evt.start = sda_dn & scl_lvl & ~scl_dn;
      evt.stop  = sda_up & scl_lvl & ~scl_dn;
      evt.rise  = scl_up;
      evt.fall  = scl_dn;
   end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h4A,
   parameter int         AW       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt,
   input  logic              sda_s,
   input  logic              gc_en,
   input  logic [BYTE_W-1:0] rf_rdata,
   output logic              sda_oe,
   output logic [AW-1:0]     rf_addr,
   output logic              rf_we,
   output logic [BYTE_W-1:0] rf_wdata,
   output logic              gc_mode
);
   localparam logic [3:0] FULL = 4'(BYTE_W);

   tgt_state_t        state;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txbuf;
   logic [AW-1:0]     ptr;
   logic              rw;
   logic              macked;
   logic              addr_own;
   logic              addr_gc;

   assign addr_own = (shreg[7:1] == DEV_ADDR);
   assign addr_gc  = (shreg[7:1] == 7'd0) && !shreg[0] && gc_en;
   assign rf_addr  = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         txbuf    <= '0;
         ptr      <= '0;
         rw       <= 1'b0;
         macked   <= 1'b0;
         sda_oe   <= 1'b0;
         rf_we    <= 1'b0;
         rf_wdata <= '0;
         gc_mode  <= 1'b0;
      end else begin
         rf_we <= 1'b0;
         if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (evt.start) begin
            state  <= ST_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_REG, ST_WR: begin
                  if (evt.rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (evt.fall && cnt == FULL) begin
                     cnt <= '0;
                     if (state == ST_DEV) begin
                        if (addr_own || addr_gc) begin
                           sda_oe  <= 1'b1;
                           rw      <= shreg[0];
                           gc_mode <= !addr_own;
                           state   <= ST_DEV_ACK;
                        end else begin
                           state <= ST_WAIT;
                        end
                     end else if (state == ST_REG) begin
                        if (!gc_mode) ptr <= shreg[AW-1:0];
                        sda_oe <= 1'b1;
                        state  <= ST_REG_ACK;
                     end else begin
                        if (!gc_mode) begin
                           rf_we    <= 1'b1;
                           rf_wdata <= shreg;
                        end
                        sda_oe <= 1'b1;
                        state  <= ST_WR_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (evt.fall) begin
                     if (rw) begin
                        txbuf  <= rf_rdata;
                        sda_oe <= ~rf_rdata[BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_REG;
                     end
                  end
               end
               ST_REG_ACK: begin
                  if (evt.fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_WR;
                  end
               end
               ST_WR_ACK: begin
                  if (evt.fall) begin
                     sda_oe <= 1'b0;
                     if (!gc_mode) ptr <= ptr + AW'(1);
                     state  <= ST_WR;
                  end
               end
               ST_TX: begin
                  if (evt.rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (evt.fall) begin
                     if (cnt == FULL) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        state  <= ST_TX_ACK;
                     end else begin
                        txbuf  <= {txbuf[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txbuf[BYTE_W-2];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (evt.rise) begin
                     macked <= ~sda_s;
                     if (!sda_s) ptr <= ptr + AW'(1);
                  end else if (evt.fall) begin
                     if (macked) begin
                        txbuf  <= rf_rdata;
                        sda_oe <= ~rf_rdata[BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h4A,
   parameter int         REG_COUNT   = 128,
   parameter int         SYNC_STAGES = 2,
   localparam int        AW          = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              gc_en,
   output logic [AW-1:0]     rf_addr,
   output logic              rf_we,
   output logic [BYTE_W-1:0] rf_wdata,
   input  logic [BYTE_W-1:0] rf_rdata
);
   if (REG_COUNT < 2 || REG_COUNT > 256 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_count
      $error("REG_COUNT must be a power of two from 2 to 256");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DEV_ADDR == 7'd0) begin : g_bad_addr
      $error("DEV_ADDR must not be the general call address");
   end

   logic [1:0] raw;
   logic [1:0] lvl;
   logic [1:0] up;
   logic [1:0] dn;
   bus_evt_t   evt;
   logic       scl_s;
   logic       stop_evt;
   logic       gc_mode;

   assign raw = {sda_i, scl_i};

   for (genvar i = 0; i < 2; i++) begin : g_line
      i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw[i]),
         .dout (lvl[i]),
         .rise (up[i]),
         .fall (dn[i])
      );
   end

   assign scl_s    = lvl[0];
   assign stop_evt = evt.stop;

   i2c_cond_detect u_cond (
      .scl_lvl(lvl[0]),
      .scl_up (up[0]),
      .scl_dn (dn[0]),
      .sda_up (up[1]),
      .sda_dn (dn[1]),
      .evt    (evt)
   );

   i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .sda_s   (lvl[1]),
      .gc_en   (gc_en),
      .rf_rdata(rf_rdata),
      .sda_oe  (sda_oe),
      .rf_addr (rf_addr),
      .rf_we   (rf_we),
      .rf_wdata(rf_wdata),
      .gc_mode (gc_mode)
   );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_oe,
   input logic rf_we,
   input logic gc_mode,
   input logic stop_evt
);
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s); // R9
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe); // R9
   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we); // R1
   AST_GC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> !gc_mode); // R7
   AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> sda_oe); // R1
endmodule

bind i2c_regfile_target i2c_tgt_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_s   (scl_s),
   .sda_oe  (sda_oe),
   .rf_we   (rf_we),
   .gc_mode (gc_mode),
   .stop_evt(stop_evt)
);

// File: tb/i2c_regfile_target_test.sv
module i2c_regfile_target_test;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;
   localparam logic [6:0] DEV = 7'h4A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic gc_en = 1'b0;
   logic sda_oe;
   logic [6:0] rf_addr;
   logic rf_we;
   logic [7:0] rf_wdata;
   logic [7:0] rf_rdata;
   logic sda_bus;
   logic exp_drive = 1'b0;

   logic [7:0] mem [128];
   logic [7:0] ref_mem [128];
   int wq_addr [$];
   int wq_data [$];
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_bus  = sda_m & ~sda_oe;
   assign rf_rdata = mem[rf_addr];

   i2c_regfile_target uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .gc_en(gc_en), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
      .rf_rdata(rf_rdata)
   );

   always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the reference model
   always @(posedge clk) begin
      #2;
      if (rst_n && scl_m) chk(!(sda_oe && !exp_drive), "R9 drive outside slot", sda_oe, 0);
      if (rst_n && rf_we) begin
         if (wq_addr.size() == 0) chk(0, "R1 unexpected write", rf_addr, 0);
         else begin
            int ea, ed;
            ea = wq_addr.pop_front();
            ed = wq_data.pop_front();
            chk(rf_addr == ea[6:0], "R1 write address", rf_addr, ea);
            chk(rf_wdata == ed[7:0], "R1 write data", rf_wdata, ed);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_put(input logic b);
      tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
   endtask

   task automatic bit_get(input logic may_drive, output logic b);
      sda_m = 1'b1; exp_drive = may_drive;
      tick(2*Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0;
      exp_drive = 1'b0;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
      chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
   endtask

   task automatic send(input logic [7:0] v, input bit exp_ack, input string req);
      logic a;
      for (int i = 7; i >= 0; i--) bit_put(v[i]);
      bit_get(exp_ack, a);
      chk((!a) == exp_ack, req, !a, exp_ack);
   endtask

   task automatic recv(input logic [7:0] exp, input bit host_ack, input string req);
      logic [7:0] v;
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_get(1'b1, b);
         v[i] = b;
      end
      bit_put(!host_ack);
      chk(v == exp, req, v, exp);
   endtask

   task automatic wr(input logic [7:0] regb, input logic [7:0] d[$], input string req);
      int p;
      p = regb[6:0];
      bus_start();
      send({DEV, 1'b0}, 1, req);
      send(regb, 1, req);
      foreach (d[i]) begin
         wq_addr.push_back(p); wq_data.push_back(d[i]);
         ref_mem[p] = d[i];
         send(d[i], 1, req);
         p = (p + 1) % 128;
      end
      bus_stop();
   endtask

   task automatic rd(input int regn, input int n, input string req);
      bus_start();
      send({DEV, 1'b0}, 1, req);
      send(8'(regn), 1, req);
      bus_start();
      send({DEV, 1'b1}, 1, req);
      for (int i = 0; i < n; i++) recv(ref_mem[(regn + i) % 128], i < n - 1, req);
      bus_stop();
   endtask

   initial begin
      logic b;
      for (int i = 0; i < 128; i++) begin
         mem[i] = 8'(i) ^ 8'hA5;
         ref_mem[i] = 8'(i) ^ 8'hA5;
      end
      tick(10);
      chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
      chk(rf_we == 1'b0, "R9 reset rf_we", rf_we, 0);
      rst_n = 1'b1;
      tick(10);

      wr(8'h05, '{8'h3C}, "R1 single write");
      rd(5, 1, "R3 single read");
      wr(8'h7E, '{8'h11, 8'h22, 8'h33}, "R2 burst write wrap");
      rd(8'h7E, 4, "R4 burst read wrap");
      wr(8'h83, '{8'h5A}, "R8 top bit ignored");
      rd(3, 1, "R8 read back reg 3");

      // R5: foreign address, later bytes ignored
      bus_start();
      send({7'h4B, 1'b0}, 0, "R5 foreign address nack");
      send(8'h00, 0, "R5 later byte ignored");
      send(8'hFF, 0, "R5 later byte ignored");
      bus_stop();

      // R6: general call disabled
      bus_start();
      send(8'h00, 0, "R6 general call disabled");
      bus_stop();

      // R7: general call enabled, acked, no writes, pointer kept at 3
      gc_en = 1'b1;
      bus_start();
      send(8'h00, 1, "R6 general call enabled");
      send(8'h05, 1, "R7 gc byte acked");
      send(8'h99, 1, "R7 gc byte acked");
      bus_stop();
      bus_start();
      send({DEV, 1'b1}, 1, "R7 read from kept pointer");
      recv(ref_mem[3], 0, "R7 pointer unchanged by gc");
      bus_stop();
      rd(5, 1, "R7 register unchanged by gc");

      // R6: read at address 0 never acked
      bus_start();
      send(8'h01, 0, "R6 gc read refused");
      bus_stop();
      gc_en = 1'b0;

      // R4: after NACK the line stays released
      bus_start();
      send({DEV, 1'b0}, 1, "R4 setup");
      send(8'h10, 1, "R4 setup");
      bus_start();
      send({DEV, 1'b1}, 1, "R4 setup");
      recv(ref_mem[16], 0, "R4 read before nack");
      for (int i = 0; i < 9; i++) begin
         bit_get(1'b0, b);
         chk(b == 1'b1, "R4 released after nack", b, 1);
      end
      bus_stop();

      tick(20);
      chk(wq_addr.size() == 0, "R1 all writes seen", wq_addr.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule